// File: doc/BRIEF.md
# Programmable Per-Channel Sampling Window Timer

This block times the sampling phase of an analog-to-digital conversion. It holds two sampling-time setups. Each setup has a 6-bit count and a 2-bit multiplier code. A per-channel select register assigns one of the two setups to each of 32 input channels. When a start pulse arrives with a channel number, the block captures the channel and the duration of that channel's setup. It then drives a sampling-active output for exactly that many clock cycles, and ends with a one-cycle done pulse.

The duration is (count + 1) times the coded multiplier. The multiplier is x1, x4, x8 or x16. If a setup uses multiplier x1 with a count below 3, the count is raised to 3 rather than rejected. While a window runs, the block is busy: it ignores configuration writes and further start pulses, so the timing of a conversion cannot change partway through.

Configuration uses a simple write port. Address 0 writes setup 0 and address 1 writes setup 1; in both, data bits [5:0] hold the count and bits [7:6] hold the multiplier code. Address 2 writes the 32-bit channel select word, where bit n belongs to channel n. Address 3 is not decoded.

Top module: `smp_window_timer`

## Requirements
- R1: After reset, busy_o, sample_o and done_o are 0 and win_chan_o is 0. Both setups hold count 32 with multiplier code 00, and the select word is all zeros, so every channel's first window lasts 33 cycles.
- R2: A window lasts (count + 1) × M cycles. M is 1 for code 00, 4 for code 01, 8 for code 10 and 16 for code 11. The count is data bits [5:0] and the code is data bits [7:6] of a setup write. For example, count 9 with code 01 gives 40 cycles.
- R3: Select bit n (data bit n of an address-2 write) picks the setup for channel n: 0 selects setup 0 (address 0) and 1 selects setup 1 (address 1).
- R4: With code 00, a count of 0, 1 or 2 is treated as 3, giving a 4-cycle window. With any other code, the count is used as written.
- R5: A write to any address is ignored while busy_o is 1, including the done cycle. Later windows use the values held before the write.
- R6: A start accepted while idle captures chan_i on win_chan_o and fixes the window duration. A start pulse while busy_o is 1 is ignored and starts no window afterwards.
- R7: done_o is 1 for exactly one cycle, in the cycle right after the last sampling cycle. busy_o is 1 in that cycle and 0 in the next.
- R8: sample_o rises in the cycle after start_i is sampled while idle, stays high for the whole window without gaps, and is high only while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Write address: 0 setup 0, 1 setup 1, 2 channel select |
| cfg_wdata_i | input | 32 | Write data |
| start_i | input | 1 | Start pulse for a sampling window |
| chan_i | input | 5 | Channel number for the start pulse |
| busy_o | output | 1 | Window or done cycle in progress |
| sample_o | output | 1 | Sampling window active |
| done_o | output | 1 | One-cycle pulse at the end of a window |
| win_chan_o | output | 5 | Channel captured at the last accepted start |

## Verification
The assertions assume that the start strobe and the write strobe are never X after reset. They also assume the shortest window is four cycles, which the clamping rule guarantees for every legal setup. The bench drives every input at the falling clock edge and keeps the strobes at a defined 0 or 1 at all times. It places in-window writes and start pulses at the third sampling cycle, and places one write in the done cycle, so that both lock edges of the busy interval are exercised.

// File: rtl/smp_pkg.sv
package smp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_DONE   = 2'd2
    } smp_state_e;

    // lowest count allowed with the x1 multiplier
    localparam int unsigned MIN_CNT_X1 = 3;

    // configuration addresses
    localparam int unsigned ADDR_SELECT = 2;

endpackage

// File: rtl/smp_setup_regs.sv
module smp_setup_regs #(
    parameter int unsigned NUM_CH     = 32,
    parameter int unsigned NUM_SETUPS = 2,
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned CODE_W     = 2,
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_RST    = 32
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                we_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    input  logic                                lock_i,
    output logic [NUM_SETUPS-1:0][CNT_W-1:0]    cnt_o,
    output logic [NUM_SETUPS-1:0][CODE_W-1:0]   code_o,
    output logic [NUM_CH-1:0]                   sel_o
);
    import smp_pkg::*;

    typedef struct packed {
        logic [NUM_SETUPS-1:0][CNT_W-1:0]  cnt;
        logic [NUM_SETUPS-1:0][CODE_W-1:0] code;
        logic [NUM_CH-1:0]                 sel;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i && !lock_i) begin
            for (int s = 0; s < NUM_SETUPS; s++) begin
                if (addr_i == ADDR_W'(s)) begin
                    regs_d.cnt[s]  = wdata_i[CNT_W-1:0];
                    regs_d.code[s] = wdata_i[CNT_W +: CODE_W];
                end
            end
            if (addr_i == ADDR_W'(ADDR_SELECT)) begin
                regs_d.sel = wdata_i[NUM_CH-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < NUM_SETUPS; s++) begin
                regs_q.cnt[s]  <= CNT_W'(CNT_RST);
                regs_q.code[s] <= '0;
            end
            regs_q.sel <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cnt_o  = regs_q.cnt;
    assign code_o = regs_q.code;
    assign sel_o  = regs_q.sel;

    // R5: nothing changes in the cycle after a locked cycle
    p_locked_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_i |=> $stable(regs_q));

endmodule

// File: rtl/smp_dur_calc.sv
module smp_dur_calc #(
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned CODE_W = 2,
    parameter int unsigned DUR_W  = 11
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DUR_W-1:0]  dur_o
);
    import smp_pkg::*;

    logic [CNT_W-1:0] eff_cnt;
    int unsigned      shift;

    always_comb begin
        eff_cnt = cnt_i;
        if (code_i == '0 && cnt_i < CNT_W'(MIN_CNT_X1)) begin
            eff_cnt = CNT_W'(MIN_CNT_X1);
        end
        case (code_i)
            2'd1:    shift = 2;
            2'd2:    shift = 3;
            2'd3:    shift = 4;
            default: shift = 0;
        endcase
        dur_o = (DUR_W'(eff_cnt) + DUR_W'(1)) << shift;
    end

endmodule

// File: rtl/smp_window_ctrl.sv
module smp_window_ctrl #(
    parameter int unsigned CH_W  = 5,
    parameter int unsigned DUR_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             busy_o,
    output logic             sample_o,
    output logic             done_o,
    output logic [CH_W-1:0]  chan_o
);
    import smp_pkg::*;

    typedef struct packed {
        smp_state_e       state;
        logic [DUR_W-1:0] rem;
        logic [CH_W-1:0]  chan;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state = ST_SAMPLE;
                    ctl_d.rem   = dur_i - DUR_W'(1);
                    ctl_d.chan  = chan_i;
                end
            end
            ST_SAMPLE: begin
                if (ctl_q.rem == '0) begin
                    ctl_d.state = ST_DONE;
                end else begin
                    ctl_d.rem = ctl_q.rem - DUR_W'(1);
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.rem   <= '0;
            ctl_q.chan  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o   = (ctl_q.state != ST_IDLE);
    assign sample_o = (ctl_q.state == ST_SAMPLE);
    assign done_o   = (ctl_q.state == ST_DONE);
    assign chan_o   = ctl_q.chan;

    // R7: done lasts one cycle and busy is gone after it
    p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

    // R7: done only right after a sampling cycle
    p_done_after_sample_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(sample_o));

    // R8: a window opens only after a start pulse
    p_sample_needs_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sample_o) |-> $past(start_i));

    // R8: sampling lies inside busy
    p_sample_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> busy_o);

    // R6: captured channel holds while busy
    p_chan_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(chan_o));

    // R4: no window is shorter than four cycles
    p_min_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sample_o) |-> (ctl_q.rem >= DUR_W'(3)));

endmodule

// File: rtl/smp_window_timer.sv
module smp_window_timer #(
    parameter int unsigned NUM_CH  = 32,
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned CODE_W  = 2,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_RST = 32
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       cfg_we_i,
    input  logic [ADDR_W-1:0]          cfg_addr_i,
    input  logic [DATA_W-1:0]          cfg_wdata_i,
    input  logic                       start_i,
    input  logic [$clog2(NUM_CH)-1:0]  chan_i,
    output logic                       busy_o,
    output logic                       sample_o,
    output logic                       done_o,
    output logic [$clog2(NUM_CH)-1:0]  win_chan_o
);
    localparam int unsigned CH_W       = $clog2(NUM_CH);
    localparam int unsigned NUM_SETUPS = 2;
    localparam int unsigned DUR_W      = CNT_W + 5;

    logic [NUM_SETUPS-1:0][CNT_W-1:0]  set_cnt;
    logic [NUM_SETUPS-1:0][CODE_W-1:0] set_code;
    logic [NUM_CH-1:0]                 ch_sel;
    logic [NUM_SETUPS-1:0][DUR_W-1:0]  set_dur;
    logic [DUR_W-1:0]                  pick_dur;

    smp_setup_regs #(
        .NUM_CH     (NUM_CH),
        .NUM_SETUPS (NUM_SETUPS),
        .CNT_W      (CNT_W),
        .CODE_W     (CODE_W),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CNT_RST    (CNT_RST)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .lock_i  (busy_o),
        .cnt_o   (set_cnt),
        .code_o  (set_code),
        .sel_o   (ch_sel)
    );

    for (genvar s = 0; s < NUM_SETUPS; s++) begin : g_dur
        smp_dur_calc #(
            .CNT_W  (CNT_W),
            .CODE_W (CODE_W),
            .DUR_W  (DUR_W)
        ) u_calc (
            .cnt_i  (set_cnt[s]),
            .code_i (set_code[s]),
            .dur_o  (set_dur[s])
        );
    end

    assign pick_dur = ch_sel[chan_i] ? set_dur[1] : set_dur[0];

    smp_window_ctrl #(
        .CH_W  (CH_W),
        .DUR_W (DUR_W)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .chan_i   (chan_i),
        .dur_i    (pick_dur),
        .busy_o   (busy_o),
        .sample_o (sample_o),
        .done_o   (done_o),
        .chan_o   (win_chan_o)
    );

    // R6: a start while busy leaves the window running
    p_busy_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o && start_i && !$past(start_i && !busy_o)) |=> busy_o);

endmodule

// File: tb/test_smp_window_timer.sv
module test_smp_window_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [4:0]  chan = '0;
    logic        busy, sample, done;
    logic [4:0]  win_chan;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smp_window_timer i_smp_window_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .start_i     (start),
        .chan_i      (chan),
        .busy_o      (busy),
        .sample_o    (sample),
        .done_o      (done),
        .win_chan_o  (win_chan)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // inj: 0 none, 1 write setup 0 mid-window, 2 start mid-window, 3 write select in done cycle
    task automatic window(input logic [4:0] ch, input int inj, input int exp, input string tag);
        int n = 0;
        @(negedge clk);
        start = 1'b1; chan = ch;
        @(negedge clk);
        start = 1'b0;
        check(sample && busy, "R8 sample after start", int'(sample), 1);
        check(win_chan == ch, "R6 channel captured", int'(win_chan), int'(ch));
        while (sample && n < 3000) begin
            n++;
            cfg_we = 1'b0; start = 1'b0;
            if (n == 3 && inj == 1) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h0A; end
            if (n == 3 && inj == 2) begin start = 1'b1; chan = ch ^ 5'd1; end
            @(negedge clk);
        end
        cfg_we = 1'b0; start = 1'b0;
        check(n == exp, tag, n, exp);
        check(done && busy, "R7 done at end of window", int'(done), 1);
        if (inj == 3) begin cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'hFFFF_FFFF; end
        @(negedge clk);
        cfg_we = 1'b0;
        check(!done && !busy, "R7 busy drops after done", int'(busy), 0);
        @(negedge clk);
        check(!busy && !sample, "R6 no extra window", int'(busy), 0);
        check(win_chan == ch, "R6 channel kept", int'(win_chan), int'(ch));
    endtask

    task automatic t_reset();
        check(!busy && !sample && !done, "R1 idle after reset", int'(busy), 0);
        check(win_chan == 5'd0, "R1 channel after reset", int'(win_chan), 0);
    endtask

    task automatic t_defaults();
        window(5'd0, 0, 33, "R1 default window ch0");
        window(5'd31, 0, 33, "R1 default window ch31");
    endtask

    task automatic t_multipliers();
        cfg_write(2'd0, 32'h49); window(5'd0, 0, 40, "R2 count9 x4");
        cfg_write(2'd0, 32'h85); window(5'd0, 0, 48, "R2 count5 x8");
        cfg_write(2'd0, 32'hFF); window(5'd0, 0, 1024, "R2 count63 x16");
        cfg_write(2'd0, 32'h0A); window(5'd0, 0, 11, "R2 count10 x1");
    endtask

    task automatic t_select();
        cfg_write(2'd0, 32'h49);
        cfg_write(2'd1, 32'h47);
        cfg_write(2'd2, 32'h8000_0020);
        window(5'd5, 0, 32, "R3 ch5 uses setup1");
        window(5'd4, 0, 40, "R3 ch4 uses setup0");
        window(5'd31, 0, 32, "R3 ch31 uses setup1");
        window(5'd30, 0, 40, "R3 ch30 uses setup0");
    endtask

    task automatic t_clamp();
        cfg_write(2'd0, 32'h01); window(5'd0, 0, 4, "R4 count1 x1 clamped");
        cfg_write(2'd0, 32'h02); window(5'd0, 0, 4, "R4 count2 x1 clamped");
        cfg_write(2'd0, 32'h00); window(5'd0, 0, 4, "R4 count0 x1 clamped");
        cfg_write(2'd0, 32'h03); window(5'd0, 0, 4, "R4 count3 x1");
        cfg_write(2'd0, 32'h40); window(5'd0, 0, 4, "R4 count0 x4 unclamped");
        cfg_write(2'd0, 32'h41); window(5'd0, 0, 8, "R4 count1 x4 unclamped");
    endtask

    task automatic t_write_lock();
        cfg_write(2'd0, 32'h49);
        window(5'd0, 1, 40, "R5 write during window");
        window(5'd0, 3, 40, "R5 setup0 kept after blocked write");
        window(5'd0, 0, 40, "R5 select kept after done-cycle write");
        window(5'd5, 0, 32, "R5 ch5 select kept");
        cfg_write(2'd0, 32'h0A);
        window(5'd0, 0, 11, "R5 idle write accepted");
    endtask

    task automatic t_busy_start();
        window(5'd4, 2, 11, "R6 start while busy ignored");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_multipliers();
        t_select();
        t_clamp();
        t_write_lock();
        t_busy_start();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule